// File: doc/BRIEF.md
# Configurable Dynamic Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of small saturating counters, one per index. The prediction port receives a fetch address and returns a taken or not-taken bit combinationally, within the same cycle. The training port receives a resolved branch address and its real outcome. On the next clock edge it moves the selected counter toward that outcome and shifts the outcome into a global history register.

The way the table is indexed is chosen at build time by the `MODE` parameter, which has four settings:
- A last-outcome mode with one bit per entry.
- An address-only mode with 2-bit counters.
- A two-level global mode that joins recent history bits with low address bits.
- A mode that XORs the low address bits with the history.

The table keeps the same size in every mode. Branches whose index bits match share one entry; this is intended and is not detected.

Top module: `branch_predictor`

## Requirements
- R1: The table has 64 entries. In the address-only and last-outcome modes the index is address bits [5:0], so addresses that differ only above bit 5 read and train the same entry.
- R2: In the counter modes an entry is 2 bits. Values 0 and 1 predict not taken, and values 2 and 3 predict taken: the prediction is the entry's upper bit.
- R3: A taken outcome raises the entry by one, stopping at 3. A not-taken outcome lowers it by one, stopping at 0. It never wraps.
- R4: In last-outcome mode each entry is one bit. It is overwritten with the resolved outcome, and the prediction is that bit.
- R5: In global mode the index is {history[2:0], address[2:0]}, with history in the upper three bits. The same address therefore reaches different entries under different histories.
- R6: In XOR mode the index is address[5:0] XOR history[5:0].
- R7: The history is 6 bits wide. Each accepted update shifts it left and places the outcome (1 = taken) in bit 0. It does not change in cycles without an update.
- R8: After reset every counter holds 1, every last-outcome bit holds 0, and the history holds 0. Every prediction is therefore not taken.
- R9: When a prediction and an update select the same entry in one cycle, the prediction reflects the entry's value before that update.
- R10: The prediction depends only on the current address and state. It is valid in the same cycle the address is presented, and training takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_addr | input | ADDR_W | Address to be predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Training request this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions check the following on every cycle:
- The history shift and hold rule.
- That the output agrees with the upper bit of the entry that the prediction index selects.
- That a counter moves only toward the outcome and stays pinned at either end.

The assertions cannot show that the index is formed correctly for each mode, that aliased addresses share an entry, or that same-cycle reads return the old value. The bench shows these by running all four modes side by side against a behavioural model, through directed history patterns and a long random stream.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [1:0] {
      BP_LAST    = 2'd0,
      BP_BIMODAL = 2'd1,
      BP_GLOBAL  = 2'd2,
      BP_GSHARE  = 2'd3
   } bp_mode_e;

   // Two-bit saturating step toward the resolved outcome.
   function automatic logic [1:0] sat2_step(input logic [1:0] cur, input logic taken);
      logic [1:0] res;
      if (taken)
         res = (cur == 2'b11) ? cur : cur + 2'b01;
      else
         res = (cur == 2'b00) ? cur : cur - 2'b01;
      return res;
   endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
   parameter int               ADDR_W    = 32,
   parameter int               IDX_W     = 6,
   parameter int               HIST_W    = 6,
   parameter int               GLOB_HIST = 3,
   parameter bp_pkg::bp_mode_e MODE      = bp_pkg::BP_GSHARE
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);
   localparam int ADDR_PART = IDX_W - GLOB_HIST;

   generate
      if (MODE == bp_pkg::BP_GSHARE) begin : g_xor
         logic [IDX_W-1:0] hist_ext;
         assign hist_ext = IDX_W'(hist);
         assign idx      = addr[IDX_W-1:0] ^ hist_ext;
      end else if (MODE == bp_pkg::BP_GLOBAL) begin : g_cat
         assign idx = {hist[GLOB_HIST-1:0], addr[ADDR_PART-1:0]};
      end else begin : g_addr
         assign idx = addr[IDX_W-1:0];
      end
   endgenerate

   // Pure combinational map: the history input is only consumed by some variants.
   logic unused_hist;
   assign unused_hist = ^hist;

endmodule

// File: rtl/bp_history.sv
module bp_history #(
   parameter int HIST_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist_q <= '0;
      else if (shift_en)
         hist_q <= {hist_q[HIST_W-2:0], shift_bit};
   end

   assign hist = hist_q;

endmodule

// File: rtl/bp_table.sv
module bp_table #(
   parameter int IDX_W = 6,
   parameter int CW    = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic                          rd_bit,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic                          wr_taken,
   output logic [((1 << IDX_W) * CW)-1:0] cells_flat
);
   localparam int               DEPTH = 1 << IDX_W;
   localparam logic [CW-1:0]    INIT  = (CW == 1) ? '0 : CW'(1);

   logic [CW-1:0] wr_old;
   logic [CW-1:0] wr_next;

   assign wr_old = cells_flat[int'(wr_idx)*CW +: CW];
   assign rd_bit = cells_flat[int'(rd_idx)*CW + CW - 1];

   generate
      if (CW == 1) begin : g_last
         assign wr_next = wr_taken;
      end else begin : g_sat
         assign wr_next = bp_pkg::sat2_step(wr_old, wr_taken);
      end
   endgenerate

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic [CW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= INIT;
            else if (wr_en && (wr_idx == IDX_W'(e)))
               q <= wr_next;
         end
         assign cells_flat[e*CW +: CW] = q;
      end
   endgenerate

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
   parameter int               ADDR_W    = 32,
   parameter int               IDX_W     = 6,
   parameter int               HIST_W    = 6,
   parameter int               GLOB_HIST = 3,
   parameter bp_pkg::bp_mode_e MODE      = bp_pkg::BP_GSHARE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_addr,
   output logic              pred_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken
);
   localparam int CW    = (MODE == bp_pkg::BP_LAST) ? 1 : 2;
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 2 || IDX_W > 10) begin : g_bad_idx
         $error("branch_predictor: IDX_W out of range");
      end
      if (HIST_W < 2 || HIST_W > IDX_W) begin : g_bad_hist
         $error("branch_predictor: HIST_W must be 2..IDX_W");
      end
      if (GLOB_HIST < 1 || GLOB_HIST >= IDX_W || GLOB_HIST > HIST_W) begin : g_bad_glob
         $error("branch_predictor: GLOB_HIST out of range");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("branch_predictor: ADDR_W narrower than index");
      end
   endgenerate

   logic [HIST_W-1:0]     ghr;
   logic [IDX_W-1:0]      pred_idx;
   logic [IDX_W-1:0]      upd_idx;
   logic [DEPTH*CW-1:0]   cells_flat;

   bp_index #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W),
      .GLOB_HIST(GLOB_HIST), .MODE(MODE)
   ) u_pidx (
      .addr(pred_addr), .hist(ghr), .idx(pred_idx)
   );

   bp_index #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W),
      .GLOB_HIST(GLOB_HIST), .MODE(MODE)
   ) u_uidx (
      .addr(upd_addr), .hist(ghr), .idx(upd_idx)
   );

   bp_history #(.HIST_W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .shift_en(upd_valid), .shift_bit(upd_taken),
      .hist(ghr)
   );

   bp_table #(.IDX_W(IDX_W), .CW(CW)) u_tab (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(pred_idx), .rd_bit(pred_taken),
      .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken),
      .cells_flat(cells_flat)
   );

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
   parameter int IDX_W  = 6,
   parameter int HIST_W = 6,
   parameter int CW     = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          upd_valid,
   input logic                          upd_taken,
   input logic                          pred_taken,
   input logic [IDX_W-1:0]              pred_idx,
   input logic [IDX_W-1:0]              upd_idx,
   input logic [HIST_W-1:0]             ghr,
   input logic [((1 << IDX_W) * CW)-1:0] cells_flat
);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   logic [CW-1:0]    old_val;
   logic [IDX_W-1:0] idx_d;
   logic [CW-1:0]    after_val;

   assign old_val = cells_flat[int'(upd_idx)*CW +: CW];

   always_ff @(posedge clk) idx_d <= upd_idx;

   assign after_val = cells_flat[int'(idx_d)*CW +: CW];

   // R7
   ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(upd_taken)});

   // R7
   ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghr));

   // R2
   pred_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken == cells_flat[int'(pred_idx)*CW + CW - 1]);

   // R3
   sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && old_val == TOP) |=> after_val == TOP);

   // R3
   sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && old_val == '0) |=> after_val == '0);

   // R3
   dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=> after_val >= $past(old_val));

   // R3
   dir_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=> after_val <= $past(old_val));

endmodule

bind branch_predictor bp_checker #(
   .IDX_W(IDX_W), .HIST_W(HIST_W), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .upd_valid(upd_valid), .upd_taken(upd_taken),
   .pred_taken(pred_taken), .pred_idx(pred_idx), .upd_idx(upd_idx),
   .ghr(ghr), .cells_flat(cells_flat)
);

// File: tb/sim_branch_predictor.sv
module sim_branch_predictor;
   import bp_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pa = '0;
   logic [31:0] ua = '0;
   logic        uv = 1'b0;
   logic        ut = 1'b0;
   logic [3:0]  pt;

   always #5 clk = ~clk;

   // pt index = mode code: 0 last, 1 address-only, 2 global, 3 XOR
   branch_predictor #(.MODE(BP_GSHARE)) u0 (
      .clk(clk), .rst_n(rst_n), .pred_addr(pa), .pred_taken(pt[3]),
      .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));
   branch_predictor #(.MODE(BP_LAST)) u1 (
      .clk(clk), .rst_n(rst_n), .pred_addr(pa), .pred_taken(pt[0]),
      .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));
   branch_predictor #(.MODE(BP_BIMODAL)) u2 (
      .clk(clk), .rst_n(rst_n), .pred_addr(pa), .pred_taken(pt[1]),
      .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));
   branch_predictor #(.MODE(BP_GLOBAL)) u3 (
      .clk(clk), .rst_n(rst_n), .pred_addr(pa), .pred_taken(pt[2]),
      .upd_valid(uv), .upd_addr(ua), .upd_taken(ut));

   int mtab [4][64];
   int mhist;
   int total = 0;
   int bad = 0;

   function automatic int m_index(int m, int a, int h);
      case (m)
         2:       return ((h & 7) << 3) | (a & 7);   // R5
         3:       return (a ^ h) & 63;               // R6
         default: return a & 63;                     // R1
      endcase
   endfunction

   function automatic bit m_pred(int m, int a);
      int v;
      v = mtab[m][m_index(m, a, mhist)];
      return (m == 0) ? (v == 1) : (v >= 2);        // R2, R4
   endfunction

   task automatic step(input int p, input bit v, input int u, input bit t, input string tag);
      @(negedge clk);
      pa = 32'(p); uv = v; ua = 32'(u); ut = t;
      #1;
      for (int m = 0; m < 4; m++) begin
         total++;
         if (pt[m] !== m_pred(m, p)) begin
            bad++;
            $display("FAIL %s mode=%0d addr=%0h got=%b expected=%b",
                     tag, m, p, pt[m], m_pred(m, p));
         end
      end
      if (v) begin
         for (int m = 0; m < 4; m++) begin
            int i;
            i = m_index(m, u, mhist);
            if (m == 0) mtab[m][i] = t;
            else if (t) mtab[m][i] = (mtab[m][i] == 3) ? 3 : mtab[m][i] + 1;   // R3
            else        mtab[m][i] = (mtab[m][i] == 0) ? 0 : mtab[m][i] - 1;
         end
         mhist = ((mhist << 1) | int'(t)) & 63;      // R7
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      for (int m = 0; m < 4; m++)
         for (int e = 0; e < 64; e++)
            mtab[m][e] = (m == 0) ? 0 : 1;           // R8
      mhist = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: all not taken after reset
      for (int a = 0; a < 70; a += 7) step(a, 0, 0, 0, "R8");

      // R10 / R2: train one address, prediction visible next cycle
      for (int k = 0; k < 4; k++) step(5, 1, 5, 1, "R10");
      for (int k = 0; k < 3; k++) step(5, 0, 0, 0, "R2");

      // R3: saturate high then drive to floor
      for (int k = 0; k < 6; k++) step(9, 1, 9, 1, "R3");
      for (int k = 0; k < 6; k++) step(9, 1, 9, 0, "R3");
      step(9, 0, 0, 0, "R3");

      // R1: alias above bit 5
      for (int k = 0; k < 3; k++) step(32'h43, 1, 32'h43, 1, "R1");
      step(3, 0, 0, 0, "R1");
      step(32'h1C3, 0, 0, 0, "R1");

      // R4: alternating outcomes
      for (int k = 0; k < 8; k++) step(12, 1, 12, k[0], "R4");

      // R5 / R6 / R7: fixed address under distinct histories
      for (int k = 0; k < 12; k++) step(20, 1, 20, (k % 3) == 0, "R5");
      for (int k = 0; k < 12; k++) step(20, 1, 33, (k % 2) == 0, "R6");
      for (int k = 0; k < 6; k++)  step(20, 0, 20, 1, "R7");

      // R9: same entry predicted and trained together
      for (int k = 0; k < 6; k++) step(27, 1, 27, 1, "R9");
      for (int k = 0; k < 6; k++) step(27, 1, 27, 0, "R9");

      // R10: random stream
      for (int k = 0; k < 3000; k++)
         step(int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
              int'($urandom_range(0, 255)), bit'($urandom_range(0, 2) != 0), "R10");

      summary();
      $finish;
   end

endmodule